// File: doc/BRIEF.md
# Lock-Step Handshake Fork

This block takes one valid/ready channel whose payload is a concatenation of N equal slices and fans it out to N valid/ready consumer channels, each of which receives its own slice. The incoming word is retired only in a cycle where every consumer accepts its slice at once, so the consumers advance together and no consumer ever runs ahead of the others on a word that cannot be split.

To guarantee this, the valid presented to each consumer is qualified by the ready of every other consumer. A consumer whose ready is low can still see its valid high when it is the only one holding back, but no consumer completes a handshake unless all of them do. The upstream ready is the combined ready of all branches. The block is purely combinational, has no clock or reset, and the payload slices are wired through regardless of valid.

The branch count and the slice width are parameters. A structural parameter selects between a prefix/suffix reduction of the "all other branches ready" terms and a direct per-branch reduction. Consumers are expected to have registered valid/ready paths.

Top module: `lockstep_fork`

## Requirements
- R1: `up_ready` is high exactly when all N bits of `dn_ready` are high.
- R2: For each branch i, `dn_valid[i]` is high exactly when `up_valid` is high and every `dn_ready[j]` with j different from i is high; the outputs follow the inputs in the same cycle, with no register in the path.
- R3: Branch i always carries bits `[i*SLICE_W +: SLICE_W]` of `up_data` on `dn_data[i*SLICE_W +: SLICE_W]`, whatever the valid and ready levels.
- R4: When `up_valid` and all `dn_ready` bits are high, every `dn_valid` bit is high and `up_ready` is high, so the word is retired and every slice is taken in that cycle.
- R5: No branch completes a handshake (`dn_valid[i]` and `dn_ready[i]` both high) unless all branches are ready in that cycle.
- R6: While `up_valid` is low, every `dn_valid` bit is low.
- R7: With `up_valid` high and exactly one branch not ready, that branch alone sees its valid high and all other branches see valid low.
- R8: With two or more branches not ready, every `dn_valid` bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| up_data | input | NUM_BRANCH*SLICE_W | Concatenated incoming word, slice i at bits i*SLICE_W upward |
| up_valid | input | 1 | Incoming word is valid |
| up_ready | output | 1 | Fork accepts the incoming word |
| dn_data | output | NUM_BRANCH*SLICE_W | Concatenated outgoing slices, one per branch |
| dn_valid | output | NUM_BRANCH | Per-branch valid, qualified by all other readies |
| dn_ready | input | NUM_BRANCH | Per-branch ready from each consumer |

## Verification
The checker assumes every input is at a known level and that no consumer derives its ready combinationally from the valid it receives, since such a path would close a loop through the fork. The bench keeps within this by driving `dn_ready` only from its own stimulus values, changed on the falling clock edge, and never from `dn_valid`. Outputs are sampled one time unit after each change of stimulus, which suits a block with no internal state.

// File: rtl/lockstep_fork_pkg.sv
package lockstep_fork_pkg;

  // Structure used to build the "every other branch is ready" terms.
  typedef enum logic {
    REDUCE_PREFIX = 1'b0,  // shared prefix and suffix AND chains
    REDUCE_DIRECT = 1'b1   // independent AND per branch
  } reduce_style_e;

  // Lowest payload bit of a given branch.
  function automatic int unsigned slice_base(int unsigned idx, int unsigned width);
    return idx * width;
  endfunction

endpackage

// File: rtl/lockstep_fork_others.sv
module lockstep_fork_others
  import lockstep_fork_pkg::*;
#(
  parameter int unsigned   NUM_BRANCH = 4,
  parameter reduce_style_e STYLE      = REDUCE_PREFIX
) (
  input  logic [NUM_BRANCH-1:0] rdy_in,
  output logic [NUM_BRANCH-1:0] others_rdy,
  output logic                  all_rdy
);

  localparam int unsigned CHAIN_W = NUM_BRANCH + 1;

  generate
    if (STYLE == REDUCE_PREFIX) begin : g_prefix
      logic [CHAIN_W-1:0] pre_and;
      logic [CHAIN_W-1:0] suf_and;

      always_comb begin
        pre_and    = '0;
        suf_and    = '0;
        pre_and[0] = 1'b1;
        for (int unsigned k = 0; k < NUM_BRANCH; k++) begin
          pre_and[k+1] = pre_and[k] & rdy_in[k];
        end
        suf_and[NUM_BRANCH] = 1'b1;
        for (int k = NUM_BRANCH - 1; k >= 0; k--) begin
          suf_and[k] = suf_and[k+1] & rdy_in[k];
        end
      end

      for (genvar b = 0; b < NUM_BRANCH; b++) begin : g_term
        assign others_rdy[b] = pre_and[b] & suf_and[b+1];
      end
      assign all_rdy = pre_and[NUM_BRANCH];
    end else begin : g_direct
      for (genvar b = 0; b < NUM_BRANCH; b++) begin : g_term
        always_comb begin
          others_rdy[b] = 1'b1;
          for (int unsigned k = 0; k < NUM_BRANCH; k++) begin
            if (k != b) begin
              others_rdy[b] = others_rdy[b] & rdy_in[k];
            end
          end
        end
      end
      assign all_rdy = &rdy_in;
    end
  endgenerate

endmodule

// File: rtl/lockstep_fork_branch.sv
module lockstep_fork_branch #(
  parameter int unsigned SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] slice_in,
  input  logic               word_valid,
  input  logic               peers_rdy,
  output logic [SLICE_W-1:0] slice_out,
  output logic               branch_valid
);

  // Payload passes straight through; only the valid is qualified.
  assign slice_out    = slice_in;
  assign branch_valid = word_valid & peers_rdy;

endmodule

// File: rtl/lockstep_fork.sv
module lockstep_fork
  import lockstep_fork_pkg::*;
#(
  parameter int unsigned   NUM_BRANCH = 4,
  parameter int unsigned   SLICE_W    = 8,
  parameter reduce_style_e STYLE      = REDUCE_PREFIX
) (
  input  logic [NUM_BRANCH*SLICE_W-1:0] up_data,
  input  logic                          up_valid,
  output logic                          up_ready,
  output logic [NUM_BRANCH*SLICE_W-1:0] dn_data,
  output logic [NUM_BRANCH-1:0]         dn_valid,
  input  logic [NUM_BRANCH-1:0]         dn_ready
);

  localparam int unsigned DATA_W = NUM_BRANCH * SLICE_W;

  logic [NUM_BRANCH-1:0] peers_rdy;
  logic                  every_rdy;

  lockstep_fork_others #(
    .NUM_BRANCH (NUM_BRANCH),
    .STYLE      (STYLE)
  ) others_i (
    .rdy_in     (dn_ready),
    .others_rdy (peers_rdy),
    .all_rdy    (every_rdy)
  );

  generate
    for (genvar b = 0; b < NUM_BRANCH; b++) begin : g_branch
      localparam int unsigned BASE = slice_base(b, SLICE_W);
      lockstep_fork_branch #(
        .SLICE_W (SLICE_W)
      ) branch_i (
        .slice_in     (up_data[BASE +: SLICE_W]),
        .word_valid   (up_valid),
        .peers_rdy    (peers_rdy[b]),
        .slice_out    (dn_data[BASE +: SLICE_W]),
        .branch_valid (dn_valid[b])
      );
    end
  endgenerate

  assign up_ready = every_rdy;

  if (DATA_W == 0) begin : g_bad_width
    $error("lockstep_fork: payload width must be non-zero");
  end

endmodule

// File: rtl/lockstep_fork_checker.sv
module lockstep_fork_checker #(
  parameter int unsigned NUM_BRANCH = 4,
  parameter int unsigned SLICE_W    = 8
) (
  input logic [NUM_BRANCH*SLICE_W-1:0] up_data,
  input logic                          up_valid,
  input logic                          up_ready,
  input logic [NUM_BRANCH*SLICE_W-1:0] dn_data,
  input logic [NUM_BRANCH-1:0]         dn_valid,
  input logic [NUM_BRANCH-1:0]         dn_ready
);

  localparam int NB = NUM_BRANCH;

  int n_rdy;
  assign n_rdy = $countones(dn_ready);

  always_comb begin
    // R1: combined ready matches a full count of branch readies
    assert_up_ready_R1: assert (up_ready == (n_rdy == NB));
    // R4: a retiring word reaches every branch
    assert_retire_all_R4: assert (!(up_valid && up_ready) || ($countones(dn_valid) == NB));
    // R6: no branch valid without an incoming word
    assert_idle_R6: assert (up_valid || (dn_valid == '0));
    // R8: two or more stalls silence every branch
    assert_multi_stall_R8: assert (n_rdy > NB - 2 || dn_valid == '0);
    // R7: a single stalled branch is the only one offered the word
    assert_single_stall_R7: assert (!(up_valid && n_rdy == NB - 1) || (dn_valid == ~dn_ready));
    for (int b = 0; b < NB; b++) begin
      // R5: any branch handshake implies a full lock-step transfer
      assert_no_partial_R5: assert (!(dn_valid[b] && dn_ready[b]) || up_ready);
      // R2: a branch valid needs the word and its peers
      assert_branch_valid_R2: assert (!dn_valid[b] || (up_valid && n_rdy >= NB - 1));
      // R3: slice routing
      assert_slice_R3: assert (dn_data[b*SLICE_W +: SLICE_W] == up_data[b*SLICE_W +: SLICE_W]);
    end
  end

endmodule

bind lockstep_fork lockstep_fork_checker #(
  .NUM_BRANCH (NUM_BRANCH),
  .SLICE_W    (SLICE_W)
) checker_i (
  .up_data  (up_data),
  .up_valid (up_valid),
  .up_ready (up_ready),
  .dn_data  (dn_data),
  .dn_valid (dn_valid),
  .dn_ready (dn_ready)
);

// File: tb/lockstep_fork_tb_top.sv
`timescale 1ns/1ps
module lockstep_fork_tb_top;

  localparam int NB = 4;
  localparam int SW = 8;
  localparam int DW = NB * SW;

  logic clk;
  logic rst_n;
  logic [DW-1:0] up_data;
  logic          up_valid;
  logic          up_ready;
  logic [DW-1:0] dn_data;
  logic [NB-1:0] dn_valid;
  logic [NB-1:0] dn_ready;

  int n_checks;
  int n_errors;
  bit done;

  lockstep_fork #(
    .NUM_BRANCH (NB),
    .SLICE_W    (SW)
  ) dut_i (
    .up_data  (up_data),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .dn_data  (dn_data),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] model_valid(input logic v, input logic [NB-1:0] r);
    logic [NB-1:0] res;
    for (int i = 0; i < NB; i++) begin
      res[i] = v;
      for (int j = 0; j < NB; j++) begin
        if (j != i && !r[j]) res[i] = 1'b0;
      end
    end
    return res;
  endfunction

  task automatic apply(input logic [DW-1:0] d, input logic v, input logic [NB-1:0] r);
    @(negedge clk);
    up_data  = d;
    up_valid = v;
    dn_ready = r;
    #1;
  endtask

  // Checks the full output set against the model for the current stimulus.
  task automatic check_all(input string scen);
    logic [NB-1:0] ev;
    logic          er;
    ev = model_valid(up_valid, dn_ready);
    er = (dn_ready == {NB{1'b1}});
    check(up_ready == er, {scen, " R1 up_ready"}, 64'(up_ready), 64'(er));
    check(dn_valid == ev, {scen, " R2 dn_valid"}, 64'(dn_valid), 64'(ev));
    for (int i = 0; i < NB; i++) begin
      logic [SW-1:0] es;
      es = SW'(up_data >> (i * SW));
      check(dn_data[i*SW +: SW] == es, {scen, " R3 slice"}, 64'(dn_data[i*SW +: SW]), 64'(es));
    end
  endtask

  task automatic t_idle();
    apply('0, 1'b0, '0);
    check(dn_valid == '0, "idle R6 dn_valid", 64'(dn_valid), 64'h0);
    check(up_ready == 1'b0, "idle R1 up_ready", 64'(up_ready), 64'h0);
    apply(32'hDEAD_BEEF, 1'b0, {NB{1'b1}});
    check(dn_valid == '0, "valid low R6 dn_valid", 64'(dn_valid), 64'h0);
    check_all("valid low");
  endtask

  task automatic t_retire();
    apply(32'h1122_3344, 1'b1, {NB{1'b1}});
    check(dn_valid == {NB{1'b1}}, "retire R4 dn_valid", 64'(dn_valid), 64'hF);
    check(up_ready == 1'b1, "retire R4 up_ready", 64'(up_ready), 64'h1);
    check_all("retire");
  endtask

  task automatic t_single_stall();
    for (int s = 0; s < NB; s++) begin
      logic [NB-1:0] r;
      r = {NB{1'b1}};
      r[s] = 1'b0;
      apply(32'hA5C3_0F96 ^ DW'(s), 1'b1, r);
      check(dn_valid == (NB'(1) << s), "single stall R7 dn_valid", 64'(dn_valid), 64'(NB'(1) << s));
      check((dn_valid & dn_ready) == '0, "single stall R5 handshake", 64'(dn_valid & dn_ready), 64'h0);
      check_all("single stall");
    end
  endtask

  task automatic t_multi_stall();
    logic [NB-1:0] pats [4] = '{4'b0011, 4'b1010, 4'b0001, 4'b0000};
    for (int p = 0; p < 4; p++) begin
      apply(32'h0102_0304 << p, 1'b1, pats[p]);
      check(dn_valid == '0, "multi stall R8 dn_valid", 64'(dn_valid), 64'h0);
      check((dn_valid & dn_ready) == '0, "multi stall R5 handshake", 64'(dn_valid & dn_ready), 64'h0);
      check_all("multi stall");
    end
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 32; k++) begin
      logic [DW-1:0] d;
      d = DW'(32'h9E37_79B9 * (k + 1));
      apply(d, k[4], k[3:0]);
      check_all("sweep R2");
    end
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    up_data  = '0;
    up_valid = 1'b0;
    dn_ready = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_retire();
    t_single_stall();
    t_multi_stall();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule